// File: doc/BRIEF.md
# Kernel Stack Guard

This block watches every stack pointer update made in the privileged (kernel) processor mode and sorts the new value into one of three zones relative to a programmable limit. The limit is given as an 8-bit upper part; its low bits are zero. A value well above the limit is normal. A value in a narrow band just above the limit raises a deferred trap request and lets the current instruction finish. A value below that band aborts the current cycle at once.

An abort starts an emergency vector sequence. This sequence never touches the stack pointer, so it cannot fail a second time on the same stack. It reads the new status word from a fixed location and saves the old status word and program counter to two other fixed locations. It then reads the new program counter and hands both loaded words to the sequencer. A memory error reported while the processor transfers through any trap vector is handled the same way as a fatal stack violation. Two sticky error flags record which zones have been entered until they are cleared.

Top module: `stack_guard`

## Requirements
- R1: Updates made while `cpu_mode` is not 0 (0 is kernel mode) never raise `red_abort`, `yellow_req`, `err_yellow` or `err_red`.
- R2: With base = `limit_hi` × 256, a kernel update with `sp_value` >= base + 256 raises nothing. The comparison is unsigned and 17 bits wide, so base + 256 does not wrap.
- R3: A kernel update with base + 224 <= `sp_value` < base + 256 gives the following. `yellow_req` is high for exactly one cycle, in the cycle after the update. `err_yellow` is set in that same cycle. `red_abort` stays low.
- R4: A kernel update with `sp_value` < base + 224 raises `red_abort` combinationally in the update cycle. `err_red` and `busy` are high from the next cycle.
- R5: After an abort, the sequence issues four memory steps in this order: a read of address 6, a write of the saved status word to address 2, a write of the saved program counter to address 0, and a read of address 4. Each step holds `mem_req` and `mem_addr` until `mem_ack`.
- R6: `busy` stays high until the last step is acknowledged. In the following cycle `busy` is low and `vec_load` pulses, with `new_psw` equal to the word read from address 6 and `new_pc` equal to the word read from address 4.
- R7: `vec_fault` raises `red_abort` in any mode, sets `err_red`, and starts the same sequence.
- R8: While `busy` is high, `sp_valid` and `vec_fault` are ignored: no abort, no new sequence, and no error flag is set.
- R9: `err_yellow` and `err_red` hold until `err_clr`. A set and a clear in the same cycle leave the flag set.
- R10: After reset all outputs are low and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_mode | input | 2 | Current processor mode, 0 = kernel |
| sp_valid | input | 1 | Strobe: `sp_value` is a new stack pointer |
| sp_value | input | 16 | New stack pointer value |
| limit_hi | input | 8 | Upper byte of the stack limit |
| vec_fault | input | 1 | Memory error during a trap vector transfer |
| cur_psw | input | 16 | Current status word, saved on abort |
| cur_pc | input | 16 | Current program counter, saved on abort |
| err_clr | input | 1 | Clears both sticky error flags |
| yellow_req | output | 1 | One-cycle deferred trap request |
| red_abort | output | 1 | Immediate cycle abort |
| err_yellow | output | 1 | Sticky warning-zone flag |
| err_red | output | 1 | Sticky fatal-zone flag |
| busy | output | 1 | Emergency sequence in progress |
| mem_req | output | 1 | Memory step request |
| mem_we | output | 1 | Step is a write |
| mem_addr | output | 16 | Step address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Step completes this cycle |
| vec_load | output | 1 | New status word and program counter are ready |
| new_psw | output | 16 | Status word loaded from address 6 |
| new_pc | output | 16 | Program counter loaded from address 4 |

## Verification
The main stimulus sets each of the 256 limit values and probes every zone edge: base − 1, base, base + 223, base + 224, base + 255 and base + 256. This separates an off-by-one at either threshold, a wrong shift of the limit and a wrap at the top of the address space. A dense sweep of every stack value across one limit window catches misclassification anywhere between the edges. The same values are replayed in the three non-kernel modes, which shows that the mode gate is honoured. The emergency sequence is run with zero-wait and with stalled acknowledges, which exposes a wrong step order or a step that advances without `mem_ack`. Stimulus applied while `busy` is high, together with a same-cycle set and clear of a flag, distinguishes lock-out and flag-priority errors.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  typedef enum logic [1:0] {
    ZONE_OK  = 2'd0,
    ZONE_YEL = 2'd1,
    ZONE_RED = 2'd2
  } zone_e;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_GET_PSW = 3'd1,
    SQ_PUT_PSW = 3'd2,
    SQ_PUT_PC  = 3'd3,
    SQ_GET_PC  = 3'd4
  } seq_e;

  // fixed emergency locations
  localparam int unsigned LOC_NEW_PSW = 6;
  localparam int unsigned LOC_OLD_PSW = 2;
  localparam int unsigned LOC_OLD_PC  = 0;
  localparam int unsigned LOC_NEW_PC  = 4;

endpackage

// File: rtl/sgd_zone_class.sv
module sgd_zone_class
  import sgd_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 8,
  parameter int YM = 256,
  parameter int RM = 224
) (
  input  logic [LW-1:0] limit_hi,
  input  logic [DW-1:0] sp,
  output zone_e         zone
);
  localparam int SH = DW - LW;
  localparam logic [DW:0] YM_X = YM;
  localparam logic [DW:0] RM_X = RM;

  // widened by one bit so limit + margin never wraps
  function automatic zone_e classify(input logic [LW-1:0] lim, input logic [DW-1:0] v);
    logic [DW:0] base;
    logic [DW:0] vx;
    base = {1'b0, lim, {SH{1'b0}}};
    vx   = {1'b0, v};
    if (vx >= base + YM_X)      classify = ZONE_OK;
    else if (vx >= base + RM_X) classify = ZONE_YEL;
    else                        classify = ZONE_RED;
  endfunction

  assign zone = classify(limit_hi, sp);

endmodule

// File: rtl/sgd_err_flags.sv
module sgd_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_yel,
  input  logic set_red,
  input  logic clr,
  output logic err_yellow,
  output logic err_red,
  output logic yellow_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_yellow <= 1'b0;
      err_red    <= 1'b0;
      yellow_req <= 1'b0;
    end else begin
      yellow_req <= set_yel;
      if (set_yel)  err_yellow <= 1'b1;
      else if (clr) err_yellow <= 1'b0;
      if (set_red)  err_red <= 1'b1;
      else if (clr) err_red <= 1'b0;
    end
  end

endmodule

// File: rtl/sgd_red_seq.sv
module sgd_red_seq
  import sgd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] cur_psw,
  input  logic [DW-1:0] cur_pc,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          vec_load,
  output logic [DW-1:0] new_psw,
  output logic [DW-1:0] new_pc
);

  seq_e          state;
  logic [DW-1:0] saved_psw;
  logic [DW-1:0] saved_pc;

  function automatic logic [DW-1:0] step_addr(input seq_e s);
    case (s)
      SQ_GET_PSW: step_addr = DW'(LOC_NEW_PSW);
      SQ_PUT_PSW: step_addr = DW'(LOC_OLD_PSW);
      SQ_PUT_PC:  step_addr = DW'(LOC_OLD_PC);
      SQ_GET_PC:  step_addr = DW'(LOC_NEW_PC);
      default:    step_addr = '0;
    endcase
  endfunction

  function automatic seq_e next_step(input seq_e s);
    case (s)
      SQ_GET_PSW: next_step = SQ_PUT_PSW;
      SQ_PUT_PSW: next_step = SQ_PUT_PC;
      SQ_PUT_PC:  next_step = SQ_GET_PC;
      default:    next_step = SQ_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      saved_psw <= '0;
      saved_pc  <= '0;
      new_psw   <= '0;
      new_pc    <= '0;
      vec_load  <= 1'b0;
    end else begin
      vec_load <= 1'b0;
      if (state == SQ_IDLE) begin
        if (start) begin
          state     <= SQ_GET_PSW;
          saved_psw <= cur_psw;
          saved_pc  <= cur_pc;
        end
      end else if (mem_ack) begin
        if (state == SQ_GET_PSW) new_psw <= mem_rdata;
        if (state == SQ_GET_PC) begin
          new_pc   <= mem_rdata;
          vec_load <= 1'b1;
        end
        state <= next_step(state);
      end
    end
  end

  always_comb begin
    busy      = (state != SQ_IDLE);
    mem_req   = busy;
    mem_we    = (state == SQ_PUT_PSW) || (state == SQ_PUT_PC);
    mem_addr  = step_addr(state);
    mem_wdata = (state == SQ_PUT_PSW) ? saved_psw :
                (state == SQ_PUT_PC)  ? saved_pc  : '0;
  end

endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import sgd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int LIM_W       = 8,
  parameter int MODE_W      = 2,
  parameter int KERNEL_MODE = 0,
  parameter int YEL_MARGIN  = 256,
  parameter int RED_MARGIN  = 224
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              sp_valid,
  input  logic [DATA_W-1:0] sp_value,
  input  logic [LIM_W-1:0]  limit_hi,
  input  logic              vec_fault,
  input  logic [DATA_W-1:0] cur_psw,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic              err_clr,
  output logic              yellow_req,
  output logic              red_abort,
  output logic              err_yellow,
  output logic              err_red,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              vec_load,
  output logic [DATA_W-1:0] new_psw,
  output logic [DATA_W-1:0] new_pc
);

  localparam logic [MODE_W-1:0] KMODE = MODE_W'(KERNEL_MODE);

  zone_e zone;
  logic  in_kernel;
  logic  chk_fire;
  logic  red_hit;
  logic  fault_hit;
  logic  yel_hit;

  sgd_zone_class #(
    .DW(DATA_W), .LW(LIM_W), .YM(YEL_MARGIN), .RM(RED_MARGIN)
  ) u_class (
    .limit_hi(limit_hi),
    .sp      (sp_value),
    .zone    (zone)
  );

  assign in_kernel = (cpu_mode == KMODE);
  assign chk_fire  = sp_valid && in_kernel && !busy;
  assign red_hit   = chk_fire && (zone == ZONE_RED);
  assign fault_hit = vec_fault && !busy;
  assign red_abort = red_hit || fault_hit;
  assign yel_hit   = chk_fire && (zone == ZONE_YEL) && !fault_hit;

  sgd_err_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_yel   (yel_hit),
    .set_red   (red_abort),
    .clr       (err_clr),
    .err_yellow(err_yellow),
    .err_red   (err_red),
    .yellow_req(yellow_req)
  );

  sgd_red_seq #(.DW(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (red_abort),
    .cur_psw  (cur_psw),
    .cur_pc   (cur_pc),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .vec_load (vec_load),
    .new_psw  (new_psw),
    .new_pc   (new_pc)
  );

endmodule

// File: rtl/stack_guard_chk.sv
module stack_guard_chk #(
  parameter int DATA_W = 16,
  parameter int MODE_W = 2,
  parameter int KERNEL_MODE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] cpu_mode,
  input logic              vec_fault,
  input logic              err_clr,
  input logic              yellow_req,
  input logic              red_abort,
  input logic              err_yellow,
  input logic              err_red,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_addr,
  input logic              vec_load,
  input logic              yel_hit
);

  a_r1_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mode != MODE_W'(KERNEL_MODE)) && !vec_fault |-> !red_abort && !yel_hit);

  a_r3_yellow_follows: assert property (@(posedge clk) disable iff (!rst_n)
    yel_hit |=> yellow_req && err_yellow);

  a_r4_red_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    red_abort |=> err_red && busy);

  a_r5_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r6_load_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> !busy && $past(busy));

  a_r8_no_abort_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !red_abort && !yel_hit);

  a_r9_red_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_red && !err_clr |=> err_red);

  a_r9_yel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_yellow && !err_clr |=> err_yellow);

endmodule

bind stack_guard stack_guard_chk #(
  .DATA_W(DATA_W), .MODE_W(MODE_W), .KERNEL_MODE(KERNEL_MODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_mode  (cpu_mode),
  .vec_fault (vec_fault),
  .err_clr   (err_clr),
  .yellow_req(yellow_req),
  .red_abort (red_abort),
  .err_yellow(err_yellow),
  .err_red   (err_red),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .vec_load  (vec_load),
  .yel_hit   (yel_hit)
);

// File: tb/stack_guard_tb.sv
`timescale 1ns/1ps
module stack_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpu_mode = 2'd0;
  logic        sp_valid = 1'b0;
  logic [15:0] sp_value = '0;
  logic [7:0]  limit_hi = '0;
  logic        vec_fault = 1'b0;
  logic [15:0] cur_psw = 16'h00E0;
  logic [15:0] cur_pc = 16'h0200;
  logic        err_clr = 1'b0;
  logic        yellow_req, red_abort, err_yellow, err_red, busy;
  logic        mem_req, mem_we, vec_load;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, new_psw, new_pc;
  logic        mem_ack;
  logic        slow = 1'b0;
  logic        tick = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [15:0] VEC_PSW = 16'hA5C3;
  localparam logic [15:0] VEC_PC  = 16'h1234;

  always #2.5 clk = ~clk;

  stack_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_mode(cpu_mode), .sp_valid(sp_valid),
    .sp_value(sp_value), .limit_hi(limit_hi), .vec_fault(vec_fault),
    .cur_psw(cur_psw), .cur_pc(cur_pc), .err_clr(err_clr),
    .yellow_req(yellow_req), .red_abort(red_abort), .err_yellow(err_yellow),
    .err_red(err_red), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .vec_load(vec_load), .new_psw(new_psw), .new_pc(new_pc)
  );

  // memory responder
  always @(posedge clk) tick <= ~tick;
  assign mem_ack   = mem_req && (!slow || tick);
  assign mem_rdata = (mem_addr == 16'd6) ? VEC_PSW :
                     (mem_addr == 16'd4) ? VEC_PC  : 16'h0000;

  logic [15:0] log_addr [0:63];
  logic        log_we   [0:63];
  logic [15:0] log_wd   [0:63];
  int          log_n = 0;
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      log_addr[log_n % 64] <= mem_addr;
      log_we[log_n % 64]   <= mem_we;
      log_wd[log_n % 64]   <= mem_wdata;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int zone_of(input int lim, input int sp);
    int base;
    base = lim * 256;
    if (sp >= base + 256) return 0;
    if (sp >= base + 224) return 1;
    return 2;
  endfunction

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic wait_seq(input string req);
    int guard = 0;
    while (busy && guard < 100) begin @(negedge clk); guard++; end
    check(vec_load === 1'b1, req, vec_load, 1);
    check(new_psw === VEC_PSW && new_pc === VEC_PC, req, {new_psw, new_pc},
          {VEC_PSW, VEC_PC});
  endtask

  // one stack update, checked against the zone rules
  task automatic apply_sp(input logic [1:0] mode, input int lim, input int sp);
    int z;
    z = (mode == 2'd0) ? zone_of(lim, sp) : 0;
    @(negedge clk);
    cpu_mode = mode; limit_hi = 8'(lim); sp_value = 16'(sp); sp_valid = 1'b1;
    #1;
    check(red_abort === (z == 2), (mode != 0) ? "R1" : "R4 abort", red_abort, z == 2);
    @(negedge clk);
    sp_valid = 1'b0;
    check(yellow_req === (z == 1), (mode != 0) ? "R1" : "R3 req", yellow_req, z == 1);
    check(err_yellow === (z == 1) && err_red === (z == 2), "R2 R3 R4 flags",
          {err_yellow, err_red}, {z == 1, z == 2});
    if (z == 2) wait_seq("R6");
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(yellow_req === 1'b0 && err_yellow === 1'b0 && err_red === 1'b0,
          "R9 clear", {yellow_req, err_yellow, err_red}, 0);
  endtask

  task automatic check_log(input int start, input string req);
    check(log_n - start == 4, req, log_n - start, 4);
    check(log_addr[start % 64] == 16'd6 && !log_we[start % 64], req,
          {log_we[start % 64], log_addr[start % 64]}, 6);
    check(log_addr[(start+1) % 64] == 16'd2 && log_we[(start+1) % 64]
          && log_wd[(start+1) % 64] == cur_psw, req, log_wd[(start+1) % 64], cur_psw);
    check(log_addr[(start+2) % 64] == 16'd0 && log_we[(start+2) % 64]
          && log_wd[(start+2) % 64] == cur_pc, req, log_wd[(start+2) % 64], cur_pc);
    check(log_addr[(start+3) % 64] == 16'd4 && !log_we[(start+3) % 64], req,
          {log_we[(start+3) % 64], log_addr[(start+3) % 64]}, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({yellow_req, red_abort, err_yellow, err_red, busy, mem_req, vec_load} == 0,
          "R10", {yellow_req, red_abort, err_yellow, err_red, busy, mem_req, vec_load}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && err_red === 1'b0, "R10", {busy, err_red}, 0);

    // R2 R3 R4: zone edges for every limit
    for (int lim = 0; lim < 256; lim++) begin
      int b;
      b = lim * 256;
      if (b > 0) apply_sp(2'd0, lim, b - 1);
      apply_sp(2'd0, lim, b);
      apply_sp(2'd0, lim, b + 223);
      apply_sp(2'd0, lim, b + 224);
      apply_sp(2'd0, lim, b + 255);
      if (b + 256 <= 65535) apply_sp(2'd0, lim, b + 256);
    end
    apply_sp(2'd0, 255, 65535);  // top of space, no wrap (R2)

    // dense sweep across one window
    for (int sp = 16'h3EF0; sp < 16'h4210; sp++) apply_sp(2'd0, 8'h40, sp);

    // R1: other modes
    for (int m = 1; m < 4; m++)
      for (int sp = 16'h3F00; sp < 16'h4140; sp += 3) apply_sp(2'(m), 8'h40, sp);

    // R5 with stalled acknowledges
    slow = 1'b1;
    cur_psw = 16'h3C10; cur_pc = 16'h7776;
    @(negedge clk);
    st = log_n;
    cpu_mode = 2'd0; limit_hi = 8'h20; sp_value = 16'h2010; sp_valid = 1'b1;
    @(negedge clk); sp_valid = 1'b0;
    wait_seq("R5 stalled");
    @(negedge clk);
    check_log(st, "R5");
    slow = 1'b0;
    clear_flags();

    // R7: vector fault in user mode
    @(negedge clk);
    st = log_n;
    cpu_mode = 2'd3; vec_fault = 1'b1; cur_psw = 16'h0F0F; cur_pc = 16'h0444;
    #1 check(red_abort === 1'b1, "R7 abort", red_abort, 1);
    @(negedge clk); vec_fault = 1'b0;
    check(err_red === 1'b1 && busy === 1'b1, "R7 flag", {err_red, busy}, 3);
    wait_seq("R7");
    @(negedge clk);
    check_log(st, "R7");
    clear_flags();

    // R8: stimulus ignored while busy
    @(negedge clk);
    cpu_mode = 2'd0; limit_hi = 8'h10; sp_value = 16'h0800; sp_valid = 1'b1;
    @(negedge clk);
    st = log_n;
    err_clr = 1'b1; vec_fault = 1'b1; sp_value = 16'h1000;
    #1 check(red_abort === 1'b0, "R8 abort", red_abort, 0);
    @(negedge clk);
    err_clr = 1'b0; vec_fault = 1'b0;
    sp_value = 16'h10F0;  // warning zone, still busy
    #1 check(red_abort === 1'b0, "R8 abort", red_abort, 0);
    @(negedge clk);
    sp_valid = 1'b0;
    check(err_red === 1'b0 && err_yellow === 1'b0 && yellow_req === 1'b0, "R8 flags",
          {err_red, err_yellow, yellow_req}, 0);
    wait_seq("R8");
    @(negedge clk);
    check(log_n - st == 4 && busy === 1'b0, "R8 single seq", log_n - st, 4);

    // R9: stickiness and set-over-clear
    @(negedge clk);
    limit_hi = 8'h10; sp_value = 16'h10E0; sp_valid = 1'b1;
    @(negedge clk); sp_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(err_yellow === 1'b1, "R9 hold", err_yellow, 1);
    sp_valid = 1'b1; err_clr = 1'b1;
    @(negedge clk); sp_valid = 1'b0; err_clr = 1'b0;
    check(err_yellow === 1'b1, "R9 set wins", err_yellow, 1);
    clear_flags();
    check(err_yellow === 1'b0, "R9 clear", err_yellow, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule